// File: doc/BRIEF.md
# Double-Buffered PWM Compare Timer

This block makes one pulse-width-modulated output from an up-counting timer. The counter climbs from zero to a programmable terminal value, then wraps to zero. Each period therefore lasts terminal value plus one clocks. The output rises at the start of each period. It falls on the clock where the count equals the active duty value, so the number of high clocks in a period equals that duty value.

The duty value is written through a data bus with a write strobe into a shadow register. A mode input selects when the shadow reaches the active compare latch.

- **Immediate mode:** the value is copied on the same clock as the write. If the duty is lowered below the current count, the fall is missed and the output stays high for a whole period. This mode reproduces that glitch on purpose.
- **Buffered mode:** the copy waits for the next period boundary, so raising or lowering the duty never disturbs the period in progress.

A run input freezes the timer. A clear input restarts the count at zero.

Top module: `pwm_buffered_timer`

## Requirements
- R1: After reset, `count` is 0, `pwm_out` is 0, and both the shadow and the active duty latches hold 0. Starting the timer with no write leaves `pwm_out` low.
- R2: While `run` is 1, `count` advances by one each clock from 0 to `period`, then returns to 0. One PWM period lasts `period`+1 clocks.
- R3: Within a period, `pwm_out` is 1 while `count` is below the active duty value and 0 from the match onward. A duty of D with D ≤ `period` gives D high clocks per period; for example, 100 or 200 out of 400 when `period` is 399.
- R4: An active duty of 0 keeps `pwm_out` low for whole periods. A duty greater than `period` keeps it high for whole periods.
- R5: With `load_imm`=1 (immediate mode), a duty write becomes active on the clock edge that samples the strobe. Lowering the duty below the current count misses the fall, so `pwm_out` stays high for the full period before the new duty appears.
- R6: With `load_imm`=0 (buffered mode), a written duty becomes active only at the next wrap of the counter. A lowered value written mid-period leaves that period unchanged and applies from the next one.
- R7: When several writes arrive within one period in buffered mode, only the last is loaded at the next wrap.
- R8: While `run` is 0 and `clear` is 0, `count` and `pwm_out` hold their values.
- R9: In buffered mode, a write made while stopped is not loaded while stopped or on restart. It is loaded only when the counter next wraps.
- R10: A `clear` pulse sets `count` to 0 on the next clock and acts as a period start. It loads the shadow in buffered mode, and `pwm_out` becomes 1 unless the active duty is 0.
- R11: If `period` is lowered below the current count, the counter wraps to 0 on the next running clock instead of counting past it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 lets the counter advance, 0 freezes it |
| clear | input | 1 | Restart the count at 0 (period start) |
| load_imm | input | 1 | 1 = immediate duty load, 0 = load at wrap |
| period | input | 16 | Terminal count; the period is this value plus 1 |
| duty_wdata | input | 16 | Duty value to write |
| duty_we | input | 1 | Write strobe for `duty_wdata` |
| pwm_out | output | 1 | PWM waveform |
| count | output | 16 | Current counter value |

## Verification
A wrong active latch shows at once in the number of high clocks of the next full period. A load at the wrong moment shows in the period where the write occurred: either as the full-high glitch in buffered mode, or as its absence in immediate mode. A counter fault appears on the `count` port on the very next clock, and a stuck output register shows within one period as a wrong high count. The bench therefore measures high clocks period by period and compares `count` on the clocks around wraps, stops and clears.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // Choice of when the shadow duty moves into the active compare latch.
    typedef enum logic {
        LOAD_AT_WRAP = 1'b0,
        LOAD_NOW     = 1'b1
    } load_mode_e;

    // Per-clock events produced by the counter for the other stages.
    typedef struct packed {
        logic adv;      // timer state may change this clock (run or clear)
        logic wrap;     // running counter reaches/exceeds terminal value
        logic load_pt;  // period start: wrap or clear
    } tick_t;

    // Next counter value for a W-bit up counter.
    function automatic logic [31:0] next_count(input logic [31:0] cur,
                                               input logic clr,
                                               input logic wrp,
                                               input logic go);
        if (clr || wrp) return 32'd0;
        if (go)         return cur + 32'd1;
        return cur;
    endfunction

endpackage

// File: rtl/pwm_tick_counter.sv
module pwm_tick_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output tick_t        tick
);

    localparam int PAD = 32 - W;

    logic [31:0] nxt_wide;

    always_comb begin
        tick.wrap    = run && !clear && (cnt >= period);
        tick.load_pt = clear || tick.wrap;
        tick.adv     = run || clear;
        nxt_wide     = next_count({{PAD{1'b0}}, cnt}, clear, tick.wrap, run);
        cnt_nxt      = nxt_wide[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    // R8
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt));

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

    // R2
    counts_up_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && cnt < period) |=> (cnt == $past(cnt) + W'(1)));

    // R11
    wraps_past_term_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !clear && cnt >= period) |=> (cnt == '0));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  load_mode_e   mode,
    input  logic         load_pt,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active,
    output logic [W-1:0] active_nxt
);

    logic [W-1:0] shadow_nxt;

    always_comb begin
        shadow_nxt = we ? wdata : shadow;
        if (mode == LOAD_NOW && we)
            active_nxt = wdata;
        else if (load_pt)
            active_nxt = shadow_nxt;
        else
            active_nxt = active;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            shadow <= shadow_nxt;
            active <= active_nxt;
        end
    end

    // R6
    buffered_holds_active_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LOAD_AT_WRAP && !load_pt) |=> $stable(active));

    // R5
    immediate_takes_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == LOAD_NOW && we) |=> (active == $past(wdata)));

    // R7
    shadow_last_write_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (shadow == $past(wdata)));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
    import pwm_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tick_t        tick,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] act_nxt,
    output logic         out
);

    logic out_nxt;

    // Match has priority over set, so a zero duty never lets a pulse out.
    always_comb begin
        out_nxt = out;
        if (tick.adv) begin
            if (cnt_nxt == act_nxt)
                out_nxt = 1'b0;
            else if (tick.load_pt)
                out_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out <= 1'b0;
        else     out <= out_nxt;
    end

    // R8
    out_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !tick.adv |=> $stable(out));

endmodule

// File: rtl/pwm_buffered_timer.sv
module pwm_buffered_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic             load_imm,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty_wdata,
    input  logic             duty_we,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count
);

    load_mode_e       mode;
    tick_t            tick;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] shadow;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] active_nxt;

    assign mode = load_mode_e'(load_imm);

    pwm_tick_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .clear   (clear),
        .period  (period),
        .cnt     (count),
        .cnt_nxt (cnt_nxt),
        .tick    (tick)
    );

    pwm_duty_latch #(.W(CNT_W)) u_duty (
        .clk        (clk),
        .rst        (rst),
        .we         (duty_we),
        .wdata      (duty_wdata),
        .mode       (mode),
        .load_pt    (tick.load_pt),
        .shadow     (shadow),
        .active     (active),
        .active_nxt (active_nxt)
    );

    pwm_out_stage #(.W(CNT_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cnt_nxt (cnt_nxt),
        .act_nxt (active_nxt),
        .out     (pwm_out)
    );

    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_out) |-> (count == '0));

    // R3
    fall_at_match_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pwm_out) |-> (count == active));

    // R4
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (rst)
        (tick.load_pt && active_nxt == '0) |=> !pwm_out);

endmodule

// File: tb/pwm_buffered_timer_tb_top.sv
module pwm_buffered_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        clear = 1'b0;
    logic        load_imm = 1'b0;
    logic [15:0] period = 16'd19;
    logic [15:0] duty_wdata = 16'd0;
    logic        duty_we = 1'b0;
    logic        pwm_out;
    logic [15:0] count;

    int n_chk = 0;
    int n_bad = 0;
    int cur_p = 19;

    always #5 clk = ~clk;

    pwm_buffered_timer dut_i (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .clear      (clear),
        .load_imm   (load_imm),
        .period     (period),
        .duty_wdata (duty_wdata),
        .duty_we    (duty_we),
        .pwm_out    (pwm_out),
        .count      (count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic sync_zero();
        step();
        while (count != 16'd0) step();
    endtask

    // Buffered write, then move to the start of the period that uses it.
    task automatic set_duty(input logic [15:0] v);
        duty_wdata = v;
        duty_we = 1'b1;
        step();
        duty_we = 1'b0;
        sync_zero();
        if (count != 0) sync_zero();
    endtask

    // Starts at a sample with count==0; counts high clocks for one period,
    // optionally writing wv on the clock where count==wr_at.
    task automatic measure(input int wr_at, input logic [15:0] wv, output int highs);
        highs = 0;
        for (int i = 0; i <= cur_p; i++) begin
            if (pwm_out) highs++;
            if (int'(count) == wr_at) begin
                duty_wdata = wv;
                duty_we = 1'b1;
            end
            step();
            duty_we = 1'b0;
        end
    endtask

    task automatic t_reset();
        int bad = 0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        check(count == 0, "R1 count", count, 0);
        check(pwm_out == 1'b0, "R1 out", pwm_out, 0);
        run = 1'b1;
        for (int i = 0; i < 45; i++) begin
            step();
            if (pwm_out) bad++;
        end
        check(bad == 0, "R1 zero latches keep out low", bad, 0);
    endtask

    task automatic t_count();
        sync_zero();
        for (int i = 0; i < cur_p; i++) step();
        check(count == 16'(cur_p), "R2 reaches period", count, cur_p);
        step();
        check(count == 0, "R2 wraps to zero", count, 0);
    endtask

    task automatic t_duty();
        int h;
        set_duty(16'd10);
        measure(-1, 0, h);
        check(h == 10, "R3 duty 10 of 20", h, 10);
        period = 16'd399;
        cur_p = 399;
        set_duty(16'd100);
        measure(-1, 0, h);
        check(h == 100, "R3 25 percent", h, 100);
        set_duty(16'd200);
        measure(-1, 0, h);
        check(h == 200, "R3 50 percent", h, 200);
        period = 16'd19;
        cur_p = 19;
        sync_zero();
    endtask

    task automatic t_corner();
        int h;
        set_duty(16'd0);
        measure(-1, 0, h);
        check(h == 0, "R4 duty zero low", h, 0);
        set_duty(16'd25);
        measure(-1, 0, h);
        check(h == 20, "R4 duty above period high", h, 20);
    endtask

    task automatic t_immediate();
        int h;
        load_imm = 1'b0;
        set_duty(16'd10);
        load_imm = 1'b1;
        measure(7, 16'd5, h);
        check(h == 20, "R5 lowered duty glitch full high", h, 20);
        measure(-1, 0, h);
        check(h == 5, "R5 new duty next period", h, 5);
        measure(3, 16'd12, h);
        check(h == 12, "R5 raised duty same period", h, 12);
        load_imm = 1'b0;
    endtask

    task automatic t_buffered();
        int h;
        set_duty(16'd10);
        measure(7, 16'd5, h);
        check(h == 10, "R6 no glitch on lowering", h, 10);
        measure(-1, 0, h);
        check(h == 5, "R6 new duty after wrap", h, 5);
    endtask

    task automatic t_multi();
        int h;
        sync_zero();
        for (int i = 0; i <= cur_p; i++) begin
            duty_we = (i == 2) || (i == 4) || (i == 6);
            duty_wdata = (i == 2) ? 16'd3 : (i == 4) ? 16'd8 : 16'd15;
            step();
        end
        duty_we = 1'b0;
        check(count == 0, "R7 aligned", count, 0);
        measure(-1, 0, h);
        check(h == 15, "R7 last write wins", h, 15);
    endtask

    task automatic t_stop();
        int h;
        logic [15:0] c0;
        logic o0;
        int bad = 0;
        set_duty(16'd10);
        while (count != 16'd5) step();
        run = 1'b0;
        step();
        c0 = count;
        o0 = pwm_out;
        for (int i = 0; i < 6; i++) begin
            step();
            if (count != c0 || pwm_out != o0) bad++;
        end
        check(bad == 0, "R8 stopped holds", bad, 0);
        // R9: buffered write while stopped
        duty_wdata = 16'd4;
        duty_we = 1'b1;
        step();
        duty_we = 1'b0;
        step(); step();
        check(count == c0, "R9 count held after write", count, c0);
        check(pwm_out == o0, "R9 out held after write", pwm_out, o0);
        run = 1'b1;
        while (count != 16'd9) step();
        check(pwm_out == 1'b1, "R9 old duty still active", pwm_out, 1);
        sync_zero();
        measure(-1, 0, h);
        check(h == 4, "R9 loaded at wrap", h, 4);
    endtask

    task automatic t_clear();
        int h;
        set_duty(16'd4);
        while (count != 16'd12) step();
        check(pwm_out == 1'b0, "R10 low before clear", pwm_out, 0);
        duty_wdata = 16'd7;
        duty_we = 1'b1;
        step();
        duty_we = 1'b0;
        clear = 1'b1;
        step();
        clear = 1'b0;
        check(count == 0, "R10 count zero", count, 0);
        check(pwm_out == 1'b1, "R10 out high", pwm_out, 1);
        measure(-1, 0, h);
        check(h == 7, "R10 clear loads shadow", h, 7);
    endtask

    task automatic t_shrink();
        while (count != 16'd15) step();
        period = 16'd10;
        step();
        check(count == 0, "R11 wrap when count above period", count, 0);
        cur_p = 10;
        step();
        check(count == 1, "R11 counting resumes", count, 1);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_count();
        t_duty();
        t_corner();
        t_immediate();
        t_buffered();
        t_multi();
        t_stop();
        t_clear();
        t_shrink();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule